// File: doc/BRIEF.md
# Double-Buffered Serial Grayscale Latch

This block is the serial front end of a sixteen-channel LED brightness controller with 12-bit intensity per channel. A 193-stage shift register takes one bit per serial clock rising edge and hands its oldest bit to a serial output, so several controllers can be chained on one data line. The uppermost stage of the register marks the frame type. When that stage is 0 on a strobe, the frame carries grayscale data. When it is 1, the frame is meant for a separate control latch outside this block.

Grayscale frames are captured in two stages. A strobe copies the 192 payload bits into a staging latch. A second, active latch feeds the PWM timing and takes the staging contents under one of three conditions: the end of a PWM cycle while automatic repeat is enabled, a grayscale strobe while timing-reset mode is enabled, or the blank bit being held at 1. The serial clock, strobe and end-of-cycle inputs are resynchronised into the system clock domain and edge-detected there. All state clears on reset, so the active vector reads as all-off until data is loaded.

Top module: `gs_dual_latch`

## Requirements
- R1: After reset, `gs_active` is all zeros, `ser_dout` is 0 and `ctrl_wr_pulse` is 0.
- R2: Each rising edge of `ser_clk` shifts the register one place toward its top stage (index 192) and loads `ser_din` into stage 0. The shift happens three system clocks after the edge, and `ser_din` is sampled with the same latency. A `ser_clk` held high, or changes of `ser_din` while the clock is steady, cause no further shift.
- R3: `ser_dout` always shows stage 192 and changes only after a serial clock edge. A bit shifted in reappears at `ser_dout` after 193 shifts, so the first bit of a frame sits in the top stage.
- R4: A `gs_strobe` rising edge while stage 192 is 0 copies stages 191..0 into the staging latch.
- R5: The payload packs channel n (0..15) into bits 12n+11..12n: channel 0 is bits 11..0 and channel 15 is bits 191..180.
- R6: A `gs_strobe` rising edge while stage 192 is 1 leaves both latches unchanged and raises `ctrl_wr_pulse` for exactly one system clock.
- R7: With `auto_repeat_en` at 1, a rising edge on `cycle_end` copies the staging latch into `gs_active`. With it at 0, `cycle_end` has no effect.
- R8: With `timing_reset_en` at 1, a grayscale strobe loads the new payload into `gs_active` in the same cycle that it loads the staging latch.
- R9: While `blank` is 1, `gs_active` follows the staging latch on every system clock.
- R10: When none of the R7–R9 conditions applies, `gs_active` keeps its value. In particular, a grayscale strobe with `timing_reset_en` and `blank` both at 0 does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled in the `clk` domain |
| ser_din | input | 1 | Serial data into stage 0 |
| gs_strobe | input | 1 | Latch strobe, acts on its rising edge |
| cycle_end | input | 1 | End-of-PWM-cycle pulse, acts on its rising edge |
| auto_repeat_en | input | 1 | Enables the copy to the active latch at cycle end |
| timing_reset_en | input | 1 | Enables the copy to the active latch on a grayscale strobe |
| blank | input | 1 | Level; while 1 the active latch tracks the staging latch |
| ser_dout | output | 1 | Top stage of the shift register |
| ctrl_wr_pulse | output | 1 | One-cycle pulse on a control-frame strobe |
| gs_active | output | 192 | Active grayscale vector, 16 channels of 12 bits |

## Verification
The bench goes after the frame-type split. A design that tested the wrong stage would write control frames into the grayscale path, or would pulse `ctrl_wr_pulse` on grayscale strobes. It checks that a grayscale strobe without timing reset leaves the active vector unchanged. A design that updated the active latch too eagerly would change the display in the middle of a cycle. It holds `ser_clk` high while `ser_din` toggles, and compares `ser_dout` with the data delayed by one full frame, which catches level-triggered shifting and an off-by-one register length. Each active-latch condition is checked on its own, and the per-channel unpacking is checked, which exposes a swapped channel order or a nibble misalignment.

// File: rtl/gsl_pkg.sv
package gsl_pkg;

  localparam int unsigned GSL_CHANNELS    = 16;
  localparam int unsigned GSL_GS_BITS     = 12;
  localparam int unsigned GSL_SYNC_STAGES = 2;

  // Indices of the edge-detected control inputs
  localparam int unsigned GSL_EV_SCLK   = 0;
  localparam int unsigned GSL_EV_STROBE = 1;
  localparam int unsigned GSL_EV_CYCEND = 2;
  localparam int unsigned GSL_NUM_EV    = 3;

  // Quasi-static mode inputs that gate the active-latch copy
  typedef struct packed {
    logic auto_repeat;
    logic timing_reset;
    logic blank;
  } gsl_mode_t;

endpackage

// File: rtl/gsl_sync_pipe.sv
module gsl_sync_pipe #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/gsl_edge_detect.sv
module gsl_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);

  logic lvl;
  logic lvl_q;

  gsl_sync_pipe #(.STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (d),
    .q     (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/gsl_shift_chain.sv
module gsl_shift_chain #(
  parameter int unsigned WIDTH = 193
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {q[WIDTH-2:0], din};
  end

endmodule

// File: rtl/gsl_gs_latches.sv
module gsl_gs_latches
  import gsl_pkg::*;
#(
  parameter int unsigned PW = 192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] payload,
  input  logic          gs_write,
  input  logic          cyc_rise,
  input  gsl_mode_t     mode,
  output logic [PW-1:0] first_q,
  output logic [PW-1:0] second_q
);

  // Any of the three conditions moves staging data into the active latch
  function automatic logic active_copy(input gsl_mode_t m, input logic wr,
                                       input logic cyc);
    return m.blank | (m.auto_repeat & cyc) | (m.timing_reset & wr);
  endfunction

  logic [PW-1:0] first_next;
  logic          second_load;

  // A copy in the same cycle as a write takes the freshly written payload
  assign first_next  = gs_write ? payload : first_q;
  assign second_load = active_copy(mode, gs_write, cyc_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= '0;
      second_q <= '0;
    end else begin
      first_q <= first_next;
      if (second_load) second_q <= first_next;
    end
  end

endmodule

// File: rtl/gs_dual_latch.sv
module gs_dual_latch
  import gsl_pkg::*;
#(
  parameter int unsigned CHANNELS    = GSL_CHANNELS,
  parameter int unsigned GS_BITS     = GSL_GS_BITS,
  parameter int unsigned SYNC_STAGES = GSL_SYNC_STAGES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ser_clk,
  input  logic                          ser_din,
  input  logic                          gs_strobe,
  input  logic                          cycle_end,
  input  logic                          auto_repeat_en,
  input  logic                          timing_reset_en,
  input  logic                          blank,
  output logic                          ser_dout,
  output logic                          ctrl_wr_pulse,
  output logic [CHANNELS*GS_BITS-1:0]   gs_active
);

  localparam int unsigned PW   = CHANNELS * GS_BITS;
  localparam int unsigned SR_W = PW + 1;

  function automatic logic frame_is_control(input logic [SR_W-1:0] sr);
    return sr[SR_W-1];
  endfunction

  function automatic logic [PW-1:0] frame_payload(input logic [SR_W-1:0] sr);
    return sr[PW-1:0];
  endfunction

  // Edge detection of the asynchronous control inputs
  logic [GSL_NUM_EV-1:0] ev_raw;
  logic [GSL_NUM_EV-1:0] ev_rise;

  assign ev_raw[GSL_EV_SCLK]   = ser_clk;
  assign ev_raw[GSL_EV_STROBE] = gs_strobe;
  assign ev_raw[GSL_EV_CYCEND] = cycle_end;

  for (genvar e = 0; e < GSL_NUM_EV; e++) begin : g_ev
    gsl_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ev_raw[e]),
      .rise  (ev_rise[e])
    );
  end

  // Named internal events
  logic sclk_rise;
  logic strobe_rise;
  logic cyc_rise;
  logic din_sync;

  assign sclk_rise   = ev_rise[GSL_EV_SCLK];
  assign strobe_rise = ev_rise[GSL_EV_STROBE];
  assign cyc_rise    = ev_rise[GSL_EV_CYCEND];

  // Data follows the same latency as the serial clock
  gsl_sync_pipe #(.STAGES(SYNC_STAGES)) u_din_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ser_din),
    .q     (din_sync)
  );

  logic [SR_W-1:0] sreg;

  gsl_shift_chain #(.WIDTH(SR_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sclk_rise),
    .din      (din_sync),
    .q        (sreg)
  );

  assign ser_dout = sreg[SR_W-1];

  // Frame type decided by the top stage
  logic gs_write;
  logic ctrl_write;

  assign gs_write   = strobe_rise & ~frame_is_control(sreg);
  assign ctrl_write = strobe_rise &  frame_is_control(sreg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_wr_pulse <= 1'b0;
    else        ctrl_wr_pulse <= ctrl_write;
  end

  gsl_mode_t       mode;
  logic [PW-1:0]   first_q;

  assign mode.auto_repeat  = auto_repeat_en;
  assign mode.timing_reset = timing_reset_en;
  assign mode.blank        = blank;

  gsl_gs_latches #(.PW(PW)) u_latches (
    .clk      (clk),
    .rst_n    (rst_n),
    .payload  (frame_payload(sreg)),
    .gs_write (gs_write),
    .cyc_rise (cyc_rise),
    .mode     (mode),
    .first_q  (first_q),
    .second_q (gs_active)
  );

endmodule

// File: rtl/gsl_checker.sv
module gsl_checker #(
  parameter int unsigned CHANNELS = 16,
  parameter int unsigned GS_BITS  = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          sclk_rise,
  input logic                          din_sync,
  input logic [CHANNELS*GS_BITS:0]     sreg,
  input logic                          ser_dout,
  input logic                          gs_write,
  input logic                          ctrl_write,
  input logic                          ctrl_wr_pulse,
  input logic                          cyc_rise,
  input logic                          auto_repeat_en,
  input logic                          timing_reset_en,
  input logic                          blank,
  input logic [CHANNELS*GS_BITS-1:0]   first_q,
  input logic [CHANNELS*GS_BITS-1:0]   gs_active
);

  localparam int unsigned PW   = CHANNELS * GS_BITS;
  localparam int unsigned SR_W = PW + 1;

  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> sreg[0] == $past(din_sync));

  p_shift_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> sreg[SR_W-1:1] == $past(sreg[SR_W-2:0]));

  p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(sreg));

  p_dout_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(ser_dout));

  p_first_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gs_write |=> first_q == $past(sreg[PW-1:0]));

  p_ctrl_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_write |=> ctrl_wr_pulse);

  p_ctrl_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_pulse |-> $past(ctrl_write));

  p_ctrl_no_touch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_write |=> $stable(first_q) && $stable(gs_active));

  p_auto_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_repeat_en && cyc_rise) |=> gs_active == first_q);

  p_trst_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_reset_en && gs_write) |=> gs_active == first_q);

  p_blank_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> gs_active == first_q);

  p_active_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(blank || (auto_repeat_en && cyc_rise) || (timing_reset_en && gs_write))
      |=> $stable(gs_active));

endmodule

bind gs_dual_latch gsl_checker #(
  .CHANNELS (CHANNELS),
  .GS_BITS  (GS_BITS)
) u_gsl_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .sclk_rise       (sclk_rise),
  .din_sync        (din_sync),
  .sreg            (sreg),
  .ser_dout        (ser_dout),
  .gs_write        (gs_write),
  .ctrl_write      (ctrl_write),
  .ctrl_wr_pulse   (ctrl_wr_pulse),
  .cyc_rise        (cyc_rise),
  .auto_repeat_en  (auto_repeat_en),
  .timing_reset_en (timing_reset_en),
  .blank           (blank),
  .first_q         (first_q),
  .gs_active       (gs_active)
);

// File: tb/test_gs_dual_latch.sv
`timescale 1ns/1ps
module test_gs_dual_latch;

  localparam int NCH  = 16;
  localparam int GSB  = 12;
  localparam int PW   = NCH * GSB;
  localparam int SR_W = PW + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic ser_clk, ser_din, gs_strobe, cycle_end;
  logic auto_repeat_en, timing_reset_en, blank;
  logic ser_dout, ctrl_wr_pulse;
  logic [PW-1:0] gs_active;

  always #5 clk = ~clk;

  gs_dual_latch i_gs_dual_latch (
    .clk             (clk),
    .rst_n           (rst_n),
    .ser_clk         (ser_clk),
    .ser_din         (ser_din),
    .gs_strobe       (gs_strobe),
    .cycle_end       (cycle_end),
    .auto_repeat_en  (auto_repeat_en),
    .timing_reset_en (timing_reset_en),
    .blank           (blank),
    .ser_dout        (ser_dout),
    .ctrl_wr_pulse   (ctrl_wr_pulse),
    .gs_active       (gs_active)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int ctrl_seen = 0;
  int ctrl_exp = 0;

  logic [SR_W-1:0] m_sr;
  logic [PW-1:0]   m_first, m_second;

  always @(negedge clk) if (rst_n === 1'b1 && ctrl_wr_pulse === 1'b1) ctrl_seen++;

  task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Channel extraction written bit by bit (R5 layout)
  function automatic logic [GSB-1:0] chan_of(input logic [PW-1:0] v, input int n);
    logic [GSB-1:0] r;
    for (int b = 0; b < GSB; b++) r[b] = v[n*GSB + b];
    return r;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); ser_din = b;
    @(negedge clk); ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_din = ~b;                // data moves while the clock stays high (R2)
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    m_sr = {m_sr[SR_W-2:0], b};
  endtask

  // First bit sent ends up in the top stage; ser_dout carries the older frame (R3)
  task automatic send_frame(input logic [SR_W-1:0] f);
    for (int i = SR_W - 1; i >= 0; i--) begin
      send_bit(f[i]);
      check("R3 ser_dout", PW'(ser_dout), PW'(m_sr[SR_W-1]));
    end
  endtask

  task automatic strobe();
    @(negedge clk); gs_strobe = 1'b1;
    repeat (4) @(negedge clk); gs_strobe = 1'b0;
    repeat (4) @(negedge clk);
    if (!m_sr[SR_W-1]) begin
      m_first = m_sr[PW-1:0];
      if (timing_reset_en) m_second = m_first;
    end else begin
      ctrl_exp++;
    end
  endtask

  task automatic pulse_cycle_end();
    @(negedge clk); cycle_end = 1'b1;
    repeat (4) @(negedge clk); cycle_end = 1'b0;
    repeat (4) @(negedge clk);
    if (auto_repeat_en) m_second = m_first;
  endtask

  task automatic do_blank();
    @(negedge clk); blank = 1'b1;
    repeat (3) @(negedge clk); blank = 1'b0;
    repeat (2) @(negedge clk);
    m_second = m_first;
  endtask

  function automatic logic [SR_W-1:0] rand_frame(input logic top);
    logic [SR_W-1:0] f;
    for (int i = 0; i < SR_W; i++) f[i] = 1'($urandom_range(0, 1));
    f[SR_W-1] = top;
    return f;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [SR_W-1:0] fa, fb, fc, fd;
    void'($urandom(32'h1D2B_7A05));
    rst_n = 1'b0; ser_clk = 0; ser_din = 0; gs_strobe = 0; cycle_end = 0;
    auto_repeat_en = 0; timing_reset_en = 0; blank = 0;
    m_sr = '0; m_first = '0; m_second = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 gs_active", gs_active, '0);
    check("R1 ser_dout", PW'(ser_dout), '0);
    check("R1 ctrl_wr_pulse", PW'(ctrl_seen), '0);

    // R4/R10: grayscale write without copy condition leaves output alone
    fa = rand_frame(1'b0);
    send_frame(fa);
    strobe();
    check("R10 write without copy", gs_active, '0);
    // R9 blank copies staging into active; R4 staging held the payload
    do_blank();
    check("R9 blank copy", gs_active, fa[PW-1:0]);
    check("R4 staging payload", gs_active, m_second);
    for (int n = 0; n < NCH; n++)
      check("R5 channel", PW'(chan_of(gs_active, n)), PW'((fa[PW-1:0] >> (n*GSB)) & 12'hFFF));

    // R3: ser_dout shows the previous frame bit by bit during the next frame
    fb = rand_frame(1'b0);
    send_frame(fb);
    check("R3 frame delay", PW'(m_sr), PW'(fb));
    strobe();
    check("R10 strobe no tr", gs_active, fa[PW-1:0]);
    pulse_cycle_end();
    check("R7 cycle end with auto off", gs_active, fa[PW-1:0]);
    auto_repeat_en = 1'b1;
    pulse_cycle_end();
    check("R7 auto copy", gs_active, fb[PW-1:0]);
    auto_repeat_en = 1'b0;

    // R8 timing reset on grayscale write
    fc = rand_frame(1'b0);
    send_frame(fc);
    timing_reset_en = 1'b1;
    strobe();
    check("R8 timing reset copy", gs_active, fc[PW-1:0]);

    // R6 control frame: pulse, latches untouched
    fd = rand_frame(1'b1);
    send_frame(fd);
    strobe();
    check("R6 ctrl pulse count", PW'(ctrl_seen), PW'(ctrl_exp));
    check("R6 active untouched", gs_active, fc[PW-1:0]);
    timing_reset_en = 1'b0;
    do_blank();
    check("R6 staging untouched", gs_active, fc[PW-1:0]);

    // Random mix
    for (int it = 0; it < 8; it++) begin
      auto_repeat_en  = 1'($urandom_range(0, 1));
      timing_reset_en = 1'($urandom_range(0, 1));
      send_frame(rand_frame(1'($urandom_range(0, 3) == 0)));
      strobe();
      check("R8 R10 random strobe", gs_active, m_second);
      check("R6 random ctrl count", PW'(ctrl_seen), PW'(ctrl_exp));
      if ($urandom_range(0, 1) == 1) begin
        pulse_cycle_end();
        check("R7 random cycle end", gs_active, m_second);
      end
      if ($urandom_range(0, 2) == 0) begin
        do_blank();
        check("R9 random blank", gs_active, m_second);
      end
    end
    finish_run();
  end

endmodule